// File: doc/BRIEF.md
# Slow Generator-Clock Detector

This block lives in the bus clock domain and watches a second, asynchronous clock that feeds a generator. It raises a live error flag whenever that clock runs slower than one sixteenth of the bus clock, and drops the flag again by itself once the clock is fast enough. The flag is a status level, not a latched event, so any capture or interrupt logic sits outside this block.

Each rising edge of the generator clock flips a toggle flop in the generator domain. The toggle crosses into the bus domain through a chain of synchronizing flops, and an edge detector turns every observed change into a one-cycle pulse. A saturating bus-domain counter measures the gap between pulses. If the gap grows past the ratio limit plus a small margin for synchronizer jitter, the flag rises. A later pulse that closes a short gap clears it. A pulse that closes a long gap leaves it set. A disable input holds the counter at zero and forces the flag low. A build option accepts a toggle signal that has already been made in the generator domain, in place of the raw clock.

Top module: `slow_clk_detector`

## Requirements
- R1: After reset, `clk_err_o` is 0, and it stays 0 for at least the first RATIO bus cycles.
- R2: With detection enabled and a generator clock period of at least 25 bus cycles, `clk_err_o` settles to 1 and stays 1.
- R3: With detection enabled and a generator clock period of at most RATIO (16) bus cycles, `clk_err_o` settles to 0 and stays 0.
- R4: When the flag is 1 and the generator clock speeds up to a period of at most RATIO bus cycles, the flag returns to 0 without any other action.
- R5: When the generator clock stops, the flag rises between 16 and 26 bus cycles after the last generator edge, given the defaults (RATIO 16, margin 2, two sync stages). The internal gap counter never exceeds RATIO plus margin (18).
- R6: While `det_dis_i` is 1, `clk_err_o` is 0 from the next bus cycle on, for any generator clock.
- R7: When `det_dis_i` returns to 0 with the generator clock stopped, the gap count restarts from zero. The flag therefore stays 0 for the next RATIO + margin − 1 (17) bus cycles and is 1 by cycle RATIO + margin + 2.
- R8: An edge that arrives after a gap of RATIO + margin or more bus cycles does not clear the flag, so a steadily slow clock gives an unbroken 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus clock, reference for the measurement |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| gen_clk_i | input | 1 | Generator clock, or a generator-domain toggle when built for toggle input |
| det_dis_i | input | 1 | 1 disables detection: counter held at zero, flag forced low |
| clk_err_o | output | 1 | Live slow-clock flag, 1 while the generator clock is too slow |

## Verification
The checker watches every cycle for four things: the gap counter stays within its saturation bound, the flag rises only on the cycle the counter crosses the limit with no edge seen, a short-gap edge clears the flag, and a long-gap edge keeps it. It also checks that disable clears both counter and flag. Behaviour that depends on the analog relation between the two clocks can only be shown by the bench's scenarios. That covers the settled level at several frequency ratios, recovery from slow to fast, the response time after the clock stops, and the restart after disable is released.

// File: rtl/scd_pkg.sv
package scd_pkg;

   // How the generator-side activity reaches the block.
   typedef enum logic [0:0] {
      SRC_RAW_CLOCK = 1'b0,   // a raw clock: toggle made internally
      SRC_TOGGLE    = 1'b1    // already a toggle, one change per period
   } src_mode_e;

   localparam int unsigned DEF_RATIO       = 16;
   localparam int unsigned DEF_MARGIN      = 2;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Width able to hold values 0..max_val.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/scd_toggle_src.sv
module scd_toggle_src
   import scd_pkg::*;
#(
   parameter src_mode_e MODE = SRC_RAW_CLOCK
) (
   input  logic gen_in,
   input  logic rst_n,
   output logic toggle_o
);

   generate
      if (MODE == SRC_RAW_CLOCK) begin : g_raw
         logic tgl_q;
         always_ff @(posedge gen_in or negedge rst_n) begin
            if (!rst_n) tgl_q <= 1'b0;
            else        tgl_q <= ~tgl_q;
         end
         assign toggle_o = tgl_q;
      end else begin : g_pass
         assign toggle_o = gen_in;
      end
   endgenerate

endmodule

// File: rtl/scd_sync.sv
module scd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $fatal(1, "scd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else if (i == 0) chain_q[i] <= d_async;
            else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/scd_gap_monitor.sv
module scd_gap_monitor #(
   parameter int unsigned LIMIT = 18,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dis,
   input  logic             tgl_sync,
   output logic             edge_pulse,
   output logic [CNT_W-1:0] gap_cnt,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] LIM_C    = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LIM_M1_C = CNT_W'(LIMIT - 1);

   logic             tgl_prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_prev_q <= 1'b0;
      else        tgl_prev_q <= tgl_sync;
   end

   assign edge_pulse = tgl_sync ^ tgl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (dis) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (edge_pulse) begin
         cnt_q <= '0;
         if (cnt_q < LIM_C) err_q <= 1'b0;
      end else begin
         if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LIM_M1_C) err_q <= 1'b1;
      end
   end

   assign gap_cnt = cnt_q;
   assign err_o   = err_q;

endmodule

// File: rtl/slow_clk_detector.sv
module slow_clk_detector
   import scd_pkg::*;
#(
   parameter int unsigned RATIO       = DEF_RATIO,
   parameter int unsigned MARGIN      = DEF_MARGIN,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter src_mode_e   SRC_MODE    = SRC_RAW_CLOCK
) (
   input  logic clk_bus,
   input  logic rst_n,
   input  logic gen_clk_i,
   input  logic det_dis_i,
   output logic clk_err_o
);

   localparam int unsigned LIMIT = RATIO + MARGIN;
   localparam int unsigned CNT_W = cnt_width(LIMIT);

   generate
      if (RATIO < 2) begin : g_chk_ratio
         $fatal(1, "slow_clk_detector: RATIO must be at least 2");
      end
      if (MARGIN < 1) begin : g_chk_margin
         $fatal(1, "slow_clk_detector: MARGIN must be at least 1");
      end
   endgenerate

   logic             tgl_raw;
   logic             tgl_sync;
   logic             edge_pulse;
   logic [CNT_W-1:0] gap_cnt;

   scd_toggle_src #(.MODE(SRC_MODE)) u_tgl (
      .gen_in   (gen_clk_i),
      .rst_n    (rst_n),
      .toggle_o (tgl_raw)
   );

   scd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk_bus),
      .rst_n   (rst_n),
      .d_async (tgl_raw),
      .q_sync  (tgl_sync)
   );

   scd_gap_monitor #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_mon (
      .clk        (clk_bus),
      .rst_n      (rst_n),
      .dis        (det_dis_i),
      .tgl_sync   (tgl_sync),
      .edge_pulse (edge_pulse),
      .gap_cnt    (gap_cnt),
      .err_o      (clk_err_o)
   );

endmodule

// File: rtl/slow_clk_detector_chk.sv
module slow_clk_detector_chk #(
   parameter int unsigned LIMIT = 18,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dis,
   input logic             edge_seen,
   input logic [CNT_W-1:0] cnt,
   input logic             err
);

   // R6: disable clears counter and flag on the next cycle
   a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dis |=> (!err && cnt == '0));

   // R5: counter saturates at the limit
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LIMIT));

   // R2 / R7: flag rises only after a full gap with no edge
   a_r2_rise_after_full_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($past(cnt) == CNT_W'(LIMIT - 1) && !$past(edge_seen) && !$past(dis)));

   // R4: an edge closing a short gap clears the flag
   a_r4_short_gap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen && !dis && cnt < CNT_W'(LIMIT)) |=> !err);

   // R8: an edge closing a long gap keeps the flag
   a_r8_long_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen && !dis && err && cnt == CNT_W'(LIMIT)) |=> err);

endmodule

bind slow_clk_detector slow_clk_detector_chk #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_chk (
   .clk       (clk_bus),
   .rst_n     (rst_n),
   .dis       (det_dis_i),
   .edge_seen (edge_pulse),
   .cnt       (gap_cnt),
   .err       (clk_err_o)
);

// File: tb/slow_clk_detector_tb.sv
`timescale 1ns/1ps
module slow_clk_detector_tb;

   localparam int NVEC = 7;
   // generator half period in ns (bus period is 4 ns), expected settled flag
   localparam int HALF_NS [NVEC] = '{4, 20, 60, 30, 100, 16, 200};
   localparam bit EXP_ERR [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic clk_bus = 1'b0;
   logic rst_n   = 1'b0;
   logic gen_clk = 1'b0;
   logic det_dis = 1'b0;
   logic clk_err;

   int  gen_half = 4;
   bit  gen_stop = 1'b0;
   int  n_checks = 0;
   int  n_errs   = 0;
   bit  done     = 1'b0;

   always #2 clk_bus = ~clk_bus;

   always begin
      if (gen_stop) begin
         gen_clk = 1'b0;
         #4;
      end else begin
         #(gen_half) gen_clk = ~gen_clk;
      end
   end

   slow_clk_detector u_dut (
      .clk_bus   (clk_bus),
      .rst_n     (rst_n),
      .gen_clk_i (gen_clk),
      .det_dis_i (det_dis),
      .clk_err_o (clk_err)
   );

   function automatic string vec_req(input int i);
      if (i == 3 || i == 5) return "R4";
      if (EXP_ERR[i]) return "R2";
      return "R3";
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk_bus);
   endtask

   // samples the flag for n cycles, returns whether it equalled v throughout
   task automatic hold_check(input int n, input bit v, input string req);
      bit ok;
      int bad;
      ok  = 1'b1;
      bad = v;
      for (int k = 0; k < n; k++) begin
         @(negedge clk_bus);
         if (clk_err !== v) begin ok = 1'b0; bad = clk_err; end
      end
      check(ok, req, bad, v);
   endtask

   initial begin
      int t;
      bit ok;
      cycles(3);
      check(clk_err === 1'b0, "R1", clk_err, 0);
      rst_n = 1'b1;
      // R1: flag low for the first RATIO cycles
      hold_check(16, 1'b0, "R1");

      // table walk: R2, R3, R4 and R8 (unbroken 1 across slow edges)
      for (int i = 0; i < NVEC; i++) begin
         gen_half = HALF_NS[i];
         cycles(250);
         hold_check(120, EXP_ERR[i], vec_req(i));
         if (EXP_ERR[i]) hold_check(150, 1'b1, "R8");
      end

      // R5: stop the clock from fast running
      gen_half = 4;
      cycles(100);
      check(clk_err === 1'b0, "R3", clk_err, 0);
      @(negedge clk_bus);
      gen_stop = 1'b1;
      t = 0;
      while (clk_err !== 1'b1 && t < 60) begin
         @(negedge clk_bus);
         t++;
      end
      check(t >= 16 && t <= 26, "R5", t, 20);
      hold_check(60, 1'b1, "R5");

      // R6: disable forces flag low while clock is stopped
      @(negedge clk_bus);
      det_dis = 1'b1;
      @(negedge clk_bus);
      check(clk_err === 1'b0, "R6", clk_err, 0);
      hold_check(50, 1'b0, "R6");
      // R6 with a slow running clock
      gen_stop = 1'b0;
      gen_half = 100;
      hold_check(200, 1'b0, "R6");
      gen_stop = 1'b1;
      cycles(20);

      // R7: restart after disable release with clock stopped
      det_dis = 1'b0;
      ok = 1'b1;
      for (int k = 1; k <= 17; k++) begin
         @(negedge clk_bus);
         if (clk_err !== 1'b0) ok = 1'b0;
      end
      check(ok, "R7", clk_err, 0);
      cycles(3);
      check(clk_err === 1'b1, "R7", clk_err, 1);

      // R4: recovery from stopped clock
      gen_stop = 1'b0;
      gen_half = 8;
      cycles(100);
      check(clk_err === 1'b0, "R4", clk_err, 0);

      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 150000; k++) begin
         @(posedge clk_bus);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule